// File: doc/BRIEF.md
# Speculative Primary-Cache Line State Tracker

This block holds the speculation bookkeeping for every line of one processor's primary data cache while that processor runs one thread of a speculatively parallelised program. Each line carries a valid bit, a tag, and three speculation flags. The read flag records that the local thread consumed the line and could be hit by a dependence violation. The own-write flag records that the local thread speculatively changed the line. The deferred-invalidate flag records that a later thread wrote the line. The block takes one local cache operation (load, store or refill) and one snooped write-bus event per cycle. Each snoop carries the writer's thread sequence number, and the block compares it with the local thread's number.

A write from an earlier (less speculative) thread drops the matching line. If the local thread had already read that line, the block pulses a violation. A write from a later (more speculative) thread must stay invisible to the local thread, so the block only sets the line's deferred-invalidate flag. All of those deferred drops are applied together when the local thread finishes. A restart discards every line the local thread wrote, in one step. This is always safe because committed data lives only in the secondary cache. The data array, the refill path and the bus arbitration are outside the block.

The sequencer has three named states. RUN accepts events and reports ready. COMMIT_FLASH is entered from RUN on thread completion and returns to RUN after one cycle. SQUASH_FLASH is entered from RUN on a detected violation or an external restart and returns to RUN after one cycle. The transitions are RUN->SQUASH_FLASH (violation or restart), RUN->COMMIT_FLASH (completion), COMMIT_FLASH->RUN and SQUASH_FLASH->RUN.

Top module: `spec_l1_tracker`

## Requirements
- R1: After reset, every line is invalid, all read, own-write and deferred-invalidate flags are 0, ready is 1 and violation is 0.
- R2: Address bits [IDX_W-1:0] select the line and the bits above them are the tag. A refill (op_kind 2) makes the line valid with that tag and clears its three flags. op_hit is 1, combinationally, exactly when the addressed line is valid and its tag equals the operation's tag.
- R3: A load (op_kind 0) that hits a line whose own-write flag is 0 sets the read flag. A load that misses, or that hits a line with own-write set, leaves the flags unchanged.
- R4: A store (op_kind 1) that hits sets the line's own-write flag. A store that misses changes nothing. op_kind 3 is no operation.
- R5: A snoop whose rank is numerically lower than local_rank (earlier thread) and that hits a valid line invalidates that line and clears its flags. If the line's read flag was set, violation is 1 in the cycle after the snoop edge.
- R6: A snoop whose rank is higher than local_rank (later thread) and that hits leaves the line valid, sets its deferred-invalidate flag and raises no violation.
- R7: A snoop with rank equal to local_rank, or one whose tag does not match a valid line, changes nothing and raises no violation.
- R8: A violation or an assertion of thread_restart in RUN moves the block to SQUASH_FLASH, where ready is 0 for one cycle. At the end of that cycle every line with own-write set becomes invalid (flags cleared), all read flags clear, and other lines keep their deferred-invalidate flags. ready is 1 the next cycle.
- R9: thread_done in RUN moves the block to COMMIT_FLASH, where ready is 0 for one cycle. At the end of that cycle every line with deferred-invalidate set becomes invalid, and all read, own-write and deferred-invalidate flags clear. ready is 1 the next cycle.
- R10: While ready is 0, operations, snoops, thread_done and thread_restart are ignored.
- R11: In RUN, a violation or thread_restart takes priority over thread_done. A snoop is judged against the line state from before the cycle, and its effect overrides a same-cycle local operation on the same line.
- R12: violation is a pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_rank | input | RANK_W | Sequence number of the local thread |
| op_valid | input | 1 | Local operation present |
| op_kind | input | 2 | 0 load, 1 store, 2 refill, 3 none |
| op_addr | input | TAG_W+IDX_W | Local operation line address |
| snoop_valid | input | 1 | Write-bus event present |
| snoop_addr | input | TAG_W+IDX_W | Written line address |
| snoop_rank | input | RANK_W | Sequence number of the writing thread |
| thread_done | input | 1 | Local thread completed |
| thread_restart | input | 1 | External request to restart the local thread |
| ready | output | 1 | Block is in RUN and accepts events |
| violation | output | 1 | One-cycle dependence violation pulse |
| op_hit | output | 1 | Local operation address hits a valid line |
| line_valid | output | LINES | Per-line valid bits |
| line_read | output | LINES | Per-line read flags |
| line_mod | output | LINES | Per-line own-write flags |
| line_preinv | output | LINES | Per-line deferred-invalidate flags |

## Verification
The assertions watch the sequencing on every cycle. They check that a violation lasts one cycle and coincides with a stall, that each stall lasts exactly one cycle, and that every return to ready finds no read or own-write flag set. They also check that no flag survives on an invalid line, that a stall or a same-rank snoop is never followed by a violation, and that a violation always follows a snoop from an earlier thread. Which individual line a given snoop drops or marks, the choice between discarding and committing at a flash, the priority of a snoop over a same-cycle local operation, and the deferral of later-thread writes until completion can only be shown by the bench's directed and interleaved scenarios, compared against its reference model.

// File: rtl/spec_l1_pkg.sv
package spec_l1_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FILL  = 2'd2,
        OP_NONE  = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        REL_SELF    = 2'd0,
        REL_OLDER   = 2'd1,
        REL_YOUNGER = 2'd2
    } rank_rel_e;

    typedef enum logic [1:0] {
        ST_RUN          = 2'd0,
        ST_COMMIT_FLASH = 2'd1,
        ST_SQUASH_FLASH = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic rd;
        logic smod;
        logic pinv;
    } line_flags_t;

endpackage

// File: rtl/spec_rank_cmp.sv
module spec_rank_cmp
    import spec_l1_pkg::*;
#(
    parameter int RANK_W = 2
) (
    input  logic [RANK_W-1:0] local_rank,
    input  logic [RANK_W-1:0] writer_rank,
    output rank_rel_e         rel
);

    // lower sequence number = earlier, less speculative thread
    always_comb begin
        if (writer_rank < local_rank) begin
            rel = REL_OLDER;
        end else if (writer_rank > local_rank) begin
            rel = REL_YOUNGER;
        end else begin
            rel = REL_SELF;
        end
    end

endmodule

// File: rtl/spec_line_slot.sv
module spec_line_slot
    import spec_l1_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              local_sel,
    input  op_kind_e          op_kind,
    input  logic [TAG_W-1:0]  op_tag,
    input  logic              snoop_sel,
    input  logic [TAG_W-1:0]  snoop_tag,
    input  rank_rel_e         snoop_rel,
    input  logic              flash_commit,
    input  logic              flash_squash,
    output line_flags_t       flags,
    output logic              op_match,
    output logic              viol_hit
);

    line_flags_t      flags_q;
    line_flags_t      flags_d;
    logic [TAG_W-1:0] tag_q;
    logic [TAG_W-1:0] tag_d;
    logic             snp_hit;

    assign flags    = flags_q;
    assign op_match = flags_q.valid && (tag_q == op_tag);
    // snoop is resolved on the state held before this cycle
    assign snp_hit  = run && snoop_sel && flags_q.valid && (tag_q == snoop_tag);
    assign viol_hit = snp_hit && (snoop_rel == REL_OLDER) && flags_q.rd;

    always_comb begin
        flags_d = flags_q;
        tag_d   = tag_q;
        if (flash_commit) begin
            if (flags_q.pinv) begin
                flags_d.valid = 1'b0;
            end
            flags_d.rd   = 1'b0;
            flags_d.smod = 1'b0;
            flags_d.pinv = 1'b0;
        end else if (flash_squash) begin
            if (flags_q.smod) begin
                flags_d.valid = 1'b0;
                flags_d.pinv  = 1'b0;
            end
            flags_d.rd   = 1'b0;
            flags_d.smod = 1'b0;
        end else if (run) begin
            if (local_sel) begin
                unique case (op_kind)
                    OP_LOAD: begin
                        if (op_match && !flags_q.smod) begin
                            flags_d.rd = 1'b1;
                        end
                    end
                    OP_STORE: begin
                        if (op_match) begin
                            flags_d.smod = 1'b1;
                        end
                    end
                    OP_FILL: begin
                        flags_d.valid = 1'b1;
                        flags_d.rd    = 1'b0;
                        flags_d.smod  = 1'b0;
                        flags_d.pinv  = 1'b0;
                        tag_d         = op_tag;
                    end
                    OP_NONE: begin
                    end
                endcase
            end
            if (snp_hit) begin
                unique case (snoop_rel)
                    REL_OLDER: begin
                        flags_d.valid = 1'b0;
                        flags_d.rd    = 1'b0;
                        flags_d.smod  = 1'b0;
                        flags_d.pinv  = 1'b0;
                    end
                    REL_YOUNGER: begin
                        flags_d.pinv = 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            tag_q   <= '0;
        end else begin
            flags_q <= flags_d;
            tag_q   <= tag_d;
        end
    end

endmodule

// File: rtl/spec_seq_fsm.sv
module spec_seq_fsm
    import spec_l1_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic thread_done,
    input  logic thread_restart,
    input  logic viol_detect,
    output logic run,
    output logic flash_commit,
    output logic flash_squash,
    output logic ready,
    output logic violation
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       pulse_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (viol_detect || thread_restart) begin
                    state_d = ST_SQUASH_FLASH;
                end else if (thread_done) begin
                    state_d = ST_COMMIT_FLASH;
                end
            end
            ST_COMMIT_FLASH: state_d = ST_RUN;
            ST_SQUASH_FLASH: state_d = ST_RUN;
            default:         state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= (state_q == ST_RUN) && viol_detect;
        end
    end

    always_comb begin
        run          = 1'b0;
        flash_commit = 1'b0;
        flash_squash = 1'b0;
        unique case (state_q)
            ST_RUN:          run          = 1'b1;
            ST_COMMIT_FLASH: flash_commit = 1'b1;
            ST_SQUASH_FLASH: flash_squash = 1'b1;
            default:         run          = 1'b0;
        endcase
        ready     = run;
        violation = pulse_q;
    end

endmodule

// File: rtl/spec_l1_tracker.sv
module spec_l1_tracker
    import spec_l1_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int TAG_W  = 6,
    parameter int RANK_W = 2,
    localparam int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RANK_W-1:0] local_rank,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [RANK_W-1:0] snoop_rank,
    input  logic              thread_done,
    input  logic              thread_restart,
    output logic              ready,
    output logic              violation,
    output logic              op_hit,
    output logic [LINES-1:0]  line_valid,
    output logic [LINES-1:0]  line_read,
    output logic [LINES-1:0]  line_mod,
    output logic [LINES-1:0]  line_preinv
);

    logic              run;
    logic              flash_commit;
    logic              flash_squash;
    rank_rel_e         snoop_rel;
    op_kind_e          kind;
    logic [IDX_W-1:0]  op_idx;
    logic [TAG_W-1:0]  op_tag;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    logic [LINES-1:0]  match_vec;
    logic [LINES-1:0]  viol_vec;
    logic              viol_any;

    assign kind    = op_kind_e'(op_kind);
    assign op_idx  = op_addr[IDX_W-1:0];
    assign op_tag  = op_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snoop_addr[IDX_W-1:0];
    assign snp_tag = snoop_addr[ADDR_W-1:IDX_W];

    spec_rank_cmp #(.RANK_W(RANK_W)) u_rank (
        .local_rank  (local_rank),
        .writer_rank (snoop_rank),
        .rel         (snoop_rel)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_flags_t fl;
        logic        lsel;
        logic        ssel;

        assign lsel = run && op_valid && (op_idx == IDX_W'(i));
        assign ssel = snoop_valid && (snp_idx == IDX_W'(i));

        spec_line_slot #(.TAG_W(TAG_W)) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .run          (run),
            .local_sel    (lsel),
            .op_kind      (kind),
            .op_tag       (op_tag),
            .snoop_sel    (ssel),
            .snoop_tag    (snp_tag),
            .snoop_rel    (snoop_rel),
            .flash_commit (flash_commit),
            .flash_squash (flash_squash),
            .flags        (fl),
            .op_match     (match_vec[i]),
            .viol_hit     (viol_vec[i])
        );

        assign line_valid[i]  = fl.valid;
        assign line_read[i]   = fl.rd;
        assign line_mod[i]    = fl.smod;
        assign line_preinv[i] = fl.pinv;
    end

    assign viol_any = |viol_vec;
    assign op_hit   = match_vec[op_idx];

    spec_seq_fsm u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .thread_done    (thread_done),
        .thread_restart (thread_restart),
        .viol_detect    (viol_any),
        .run            (run),
        .flash_commit   (flash_commit),
        .flash_squash   (flash_squash),
        .ready          (ready),
        .violation      (violation)
    );

endmodule

// File: rtl/spec_l1_tracker_chk.sv
module spec_l1_tracker_chk #(
    parameter int LINES  = 8,
    parameter int RANK_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RANK_W-1:0] local_rank,
    input logic              snoop_valid,
    input logic [RANK_W-1:0] snoop_rank,
    input logic              ready,
    input logic              violation,
    input logic [LINES-1:0]  line_valid,
    input logic [LINES-1:0]  line_read,
    input logic [LINES-1:0]  line_mod,
    input logic [LINES-1:0]  line_preinv
);

    a_r12_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> !violation);

    a_r8_violation_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> !ready);

    a_r9_stall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ready);

    a_r8_ready_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (line_read == '0 && line_mod == '0));

    a_r3_read_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (line_read & ~line_valid) == '0);

    a_r4_mod_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (line_mod & ~line_valid) == '0);

    a_r6_preinv_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (line_preinv & ~line_valid) == '0);

    a_r7_self_rank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && snoop_valid && snoop_rank == local_rank) |=> !violation);

    a_r10_stall_no_violation: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !violation);

    a_r5_older_writer_cause: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $past(snoop_valid && (snoop_rank < local_rank)));

endmodule

bind spec_l1_tracker spec_l1_tracker_chk #(
    .LINES  (LINES),
    .RANK_W (RANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .local_rank  (local_rank),
    .snoop_valid (snoop_valid),
    .snoop_rank  (snoop_rank),
    .ready       (ready),
    .violation   (violation),
    .line_valid  (line_valid),
    .line_read   (line_read),
    .line_mod    (line_mod),
    .line_preinv (line_preinv)
);

// File: tb/sim_spec_l1_tracker.sv
module sim_spec_l1_tracker;

    localparam int LINES  = 8;
    localparam int TAG_W  = 6;
    localparam int RANK_W = 2;
    localparam int IDX_W  = 3;
    localparam int ADDR_W = TAG_W + IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RANK_W-1:0] local_rank = 2'd2;
    logic              op_valid = 1'b0;
    logic [1:0]        op_kind = 2'd3;
    logic [ADDR_W-1:0] op_addr = '0;
    logic              snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic [RANK_W-1:0] snoop_rank = '0;
    logic              thread_done = 1'b0;
    logic              thread_restart = 1'b0;
    logic              ready;
    logic              violation;
    logic              op_hit;
    logic [LINES-1:0]  line_valid;
    logic [LINES-1:0]  line_read;
    logic [LINES-1:0]  line_mod;
    logic [LINES-1:0]  line_preinv;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model
    bit mv[LINES];
    bit mr[LINES];
    bit mm[LINES];
    bit mp[LINES];
    int mt[LINES];
    int mstate;   // 0 run, 1 commit flash, 2 squash flash
    bit mviol;

    always #2 clk = ~clk;

    spec_l1_tracker #(.LINES(LINES), .TAG_W(TAG_W), .RANK_W(RANK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .local_rank(local_rank),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .snoop_rank(snoop_rank),
        .thread_done(thread_done), .thread_restart(thread_restart),
        .ready(ready), .violation(violation), .op_hit(op_hit),
        .line_valid(line_valid), .line_read(line_read),
        .line_mod(line_mod), .line_preinv(line_preinv)
    );

    function automatic int mk(input int tag, input int idx);
        return tag * LINES + idx;
    endfunction

    task automatic chk_vec(input string req, input string what,
                           input logic [LINES-1:0] got, input logic [LINES-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what,
                           input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
        end
    endtask

    task automatic compare_all(input string req);
        logic [LINES-1:0] ev, er, em, ep;
        for (int i = 0; i < LINES; i++) begin
            ev[i] = mv[i]; er[i] = mr[i]; em[i] = mm[i]; ep[i] = mp[i];
        end
        chk_vec(req, "line_valid", line_valid, ev);
        chk_vec(req, "line_read", line_read, er);
        chk_vec(req, "line_mod", line_mod, em);
        chk_vec(req, "line_preinv", line_preinv, ep);
        chk_bit(req, "ready", ready, mstate == 0);
        chk_bit(req, "violation", violation, mviol);
    endtask

    task automatic model_reset();
        for (int i = 0; i < LINES; i++) begin
            mv[i] = 0; mr[i] = 0; mm[i] = 0; mp[i] = 0; mt[i] = 0;
        end
        mstate = 0;
        mviol = 0;
    endtask

    task automatic model_edge();
        int oi, ot, si, st;
        bit shit, v;
        bit orr, yng;
        oi = int'(op_addr) % LINES;  ot = int'(op_addr) / LINES;
        si = int'(snoop_addr) % LINES; st = int'(snoop_addr) / LINES;
        if (mstate == 1) begin
            for (int i = 0; i < LINES; i++) begin
                if (mp[i]) mv[i] = 0;
                mr[i] = 0; mm[i] = 0; mp[i] = 0;
            end
            mstate = 0; mviol = 0;
        end else if (mstate == 2) begin
            for (int i = 0; i < LINES; i++) begin
                if (mm[i]) begin mv[i] = 0; mp[i] = 0; end
                mr[i] = 0; mm[i] = 0;
            end
            mstate = 0; mviol = 0;
        end else begin
            orr  = snoop_rank < local_rank;
            yng  = snoop_rank > local_rank;
            shit = snoop_valid && mv[si] && mt[si] == st;
            v    = shit && orr && mr[si];
            if (op_valid) begin
                if (op_kind == 2'd0 && mv[oi] && mt[oi] == ot && !mm[oi]) mr[oi] = 1;
                if (op_kind == 2'd1 && mv[oi] && mt[oi] == ot) mm[oi] = 1;
                if (op_kind == 2'd2) begin
                    mv[oi] = 1; mt[oi] = ot; mr[oi] = 0; mm[oi] = 0; mp[oi] = 0;
                end
            end
            if (shit && orr) begin
                mv[si] = 0; mr[si] = 0; mm[si] = 0; mp[si] = 0;
            end
            if (shit && yng) mp[si] = 1;
            mviol = v;
            if (v || thread_restart) mstate = 2;
            else if (thread_done) mstate = 1;
        end
    endtask

    // one clock: compare state, drive, check hit, clock edge, update model
    task automatic step(input string req, input bit ov, input int ok, input int oaddr,
                        input bit sv, input int saddr, input int srank,
                        input bit dn, input bit rs);
        bit exp_hit;
        compare_all(req);
        op_valid = ov; op_kind = 2'(ok); op_addr = ADDR_W'(oaddr);
        snoop_valid = sv; snoop_addr = ADDR_W'(saddr); snoop_rank = RANK_W'(srank);
        thread_done = dn; thread_restart = rs;
        #1;
        if (ov) begin
            exp_hit = mv[oaddr % LINES] && mt[oaddr % LINES] == oaddr / LINES;
            chk_bit("R2", "op_hit", op_hit, exp_hit);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input string req);
        step(req, 0, 3, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic op(input string req, input int k, input int addr);
        step(req, 1, k, addr, 0, 0, 0, 0, 0);
    endtask

    task automatic snp(input string req, input int addr, input int rank);
        step(req, 0, 3, 0, 1, addr, rank, 0, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1");

        // R2: refill every line
        for (int i = 0; i < LINES; i++) op("R2", 2, mk(i + 1, i));
        op("R2", 0, mk(9, 0));          // tag mismatch load: no hit, no read (R3)
        idle("R3");
        op("R3", 0, mk(2, 1));
        op("R3", 0, mk(3, 2));
        op("R4", 1, mk(4, 3));
        op("R3", 0, mk(4, 3));          // load on own-written line: read stays 0
        op("R4", 1, mk(7, 4));          // store miss
        op("R4", 3, mk(5, 4));          // no operation
        idle("R4");

        // R6: later-thread writes
        snp("R6", mk(6, 5), 3);
        snp("R6", mk(2, 1), 3);
        idle("R6");
        // R7: same rank and miss
        snp("R7", mk(3, 2), 2);
        snp("R7", mk(9, 2), 0);
        idle("R7");
        // R5: earlier-thread write on unread line
        snp("R5", mk(5, 4), 1);
        idle("R5");
        // R5/R8/R12: earlier write on a read line, stall inputs ignored (R10)
        snp("R5", mk(3, 2), 0);
        step("R10", 1, 1, mk(1, 0), 1, mk(6, 5), 1, 1, 1);
        idle("R8");
        idle("R12");

        // R9: commit with deferred invalidates
        op("R9", 2, mk(10, 4));
        op("R9", 0, mk(10, 4));
        op("R9", 1, mk(1, 0));
        snp("R9", mk(8, 7), 3);
        step("R9", 0, 3, 0, 0, 0, 0, 1, 0);
        step("R10", 1, 2, mk(11, 6), 1, mk(7, 6), 1, 0, 1);
        idle("R9");

        // R8: external restart keeps deferred flags on surviving lines
        op("R8", 2, mk(12, 3));
        op("R8", 1, mk(12, 3));
        snp("R8", mk(12, 3), 3);
        snp("R8", mk(7, 6), 3);
        op("R8", 0, mk(7, 6));
        step("R8", 0, 3, 0, 0, 0, 0, 0, 1);
        idle("R8");

        // R11: priorities
        op("R11", 0, mk(2, 1));
        step("R11", 0, 3, 0, 0, 0, 0, 1, 1);      // restart beats done
        idle("R11");
        op("R11", 2, mk(13, 5));
        op("R11", 0, mk(13, 5));
        step("R11", 0, 3, 0, 1, mk(13, 5), 1, 1, 0); // violation beats done
        idle("R11");
        op("R11", 2, mk(14, 2));
        step("R11", 1, 2, mk(15, 2), 1, mk(14, 2), 0, 0, 0); // older snoop overrides fill
        step("R11", 1, 1, mk(2, 1), 1, mk(2, 1), 3, 0, 0);   // store and later snoop
        step("R11", 1, 0, mk(7, 6), 1, mk(7, 6), 1, 0, 0);   // load, older snoop same line
        idle("R11");

        // other local ranks
        local_rank = 2'd0;
        op("R6", 2, mk(20, 7));
        snp("R6", mk(20, 7), 3);
        snp("R7", mk(20, 7), 0);
        local_rank = 2'd3;
        op("R5", 0, mk(20, 7));
        snp("R5", mk(20, 7), 0);
        idle("R12");
        idle("R5");
        local_rank = 2'd2;

        // interleaved mix
        for (int n = 0; n < 600; n++) begin
            int k, a, s, r, ov, sv, dn, rs;
            k  = int'($urandom % 4);
            a  = mk(int'($urandom % 3), int'($urandom % LINES));
            s  = mk(int'($urandom % 3), int'($urandom % LINES));
            r  = int'($urandom % 4);
            ov = int'($urandom % 4 != 0);
            sv = int'($urandom % 3 == 0);
            dn = int'($urandom % 24 == 0);
            rs = int'($urandom % 40 == 0);
            if (n % 100 == 50) local_rank = RANK_W'($urandom % 4);
            step("R11", bit'(ov), k, a, bit'(sv), s, r, bit'(dn), bit'(rs));
        end
        idle("R11");

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule